// File: doc/BRIEF.md
# Two-wire master control/status interrupt front end

This block is the register and interrupt side of a two-wire (I2C-style) bus master controller. It holds the control byte and the status byte, and it decodes a small byte-addressed register bus. It raises one level-sensitive interrupt line. The abstract bus engine that moves the wires reports each finished bus phase as a one-cycle event that carries a new status code. Software reads that code, programs the next step through the control byte, and then acknowledges the interrupt.

How the interrupt flag is acknowledged is fixed when the block is built. With `CLEAR_ON_ONE` = 0, a control write whose flag bit is 0 clears the flag. With `CLEAR_ON_ONE` = 1, only a 1 written to the flag bit clears it, and a 0 leaves it as it was. Some control writes also change the status byte directly: a stop request returns it to idle, and withdrawing the acknowledge after a received byte turns the ACK code into the NACK code.

Engine events use a valid-only stream. The block takes an event in any cycle in which `evt_valid` is high, so it never applies back-pressure, and the engine must not hold `evt_valid` high for more than one cycle per event. The control outputs and `irq` are plain level pins.

Top module: `twi_irq_front`

## Requirements
- R1: After reset the control byte reads 0x00, the status byte reads 0xF8 (idle) and `irq` is low.
- R2: An event (`evt_valid` high) loads `evt_code` into the status byte and sets the interrupt flag (control bit 3). Both changes are visible from the next cycle.
- R3: `irq` is high exactly when the interrupt flag and interrupt enable (control bit 7) are both 1.
- R4: With `CLEAR_ON_ONE` = 0, a write to offset 0x0C with bit 3 = 0 clears the flag. With bit 3 = 1, the flag keeps its value.
- R5: With `CLEAR_ON_ONE` = 1, a write to offset 0x0C with bit 3 = 1 clears the flag. With bit 3 = 0, the flag keeps its value.
- R6: A control write with bit 4 (stop) set puts the status byte at 0xF8. The stop bit always reads back as 0.
- R7: A control write with bit 2 (acknowledge) = 0 changes the status from 0x50 (byte received, ACK) to 0x58 (byte received, NACK). It leaves every other status code unchanged.
- R8: When an event and a control write fall in the same cycle, the event sets both the flag and the status byte, and that write's clear, stop and acknowledge effects are dropped.
- R9: A read request gives `rvalid` high on the next cycle. `rdata` then holds the control byte (offset 0x0C), the status byte (offset 0x10), or 0 for any other offset.
- R10: The status byte is read-only: writes to offset 0x10 change nothing.
- R11: Control bits 7, 6, 5, 2, 1 and 0 store the written value and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Register access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| evt_valid | input | 1 | Engine event strobe |
| evt_code | input | 8 | Status code carried by the event |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds two copies side by side: one with `CLEAR_ON_ONE` = 0 and one with `CLEAR_ON_ONE` = 1. It drives the same register and event stream into both. The same write sequence therefore checks each flag polarity against the other: the same byte clears the flag in one copy and keeps it in the other. That shows directly in `irq` and in the readback. Both copies also get events that collide with clearing, stop and acknowledge writes, so the precedence rules are checked in both modes.

// File: rtl/twi_fe_pkg.sv
package twi_fe_pkg;
  typedef logic [7:0] byte_t;

  // control bit positions (software-visible)
  localparam int CB_IEN  = 7;
  localparam int CB_BEN  = 6;
  localparam int CB_SP5  = 5;
  localparam int CB_STOP = 4;
  localparam int CB_FLAG = 3;
  localparam int CB_ACK  = 2;

  // status codes handled inside the block
  localparam byte_t ST_IDLE    = 8'hF8;
  localparam byte_t ST_RX_ACK  = 8'h50;
  localparam byte_t ST_RX_NACK = 8'h58;

  typedef struct packed {
    logic       ien;
    logic       ben;
    logic       sp5;
    logic       flag;
    logic       ack;
    logic [1:0] lo;
  } ctl_t;

  function automatic byte_t ctl_to_byte(ctl_t c);
    byte_t b;
    b          = '0;
    b[CB_IEN]  = c.ien;
    b[CB_BEN]  = c.ben;
    b[CB_SP5]  = c.sp5;
    b[CB_FLAG] = c.flag;
    b[CB_ACK]  = c.ack;
    b[1:0]     = c.lo;
    return b;
  endfunction
endpackage

// File: rtl/twi_fe_decode.sv
module twi_fe_decode #(
  parameter int ADDR_W    = 6,
  parameter int WIN_BYTES = 36,
  parameter int CTL_OFF   = 12,
  parameter int STS_OFF   = 16
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              ctl_wr,
  output logic              ctl_rd,
  output logic              sts_rd,
  output logic              any_rd
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFF);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFF);
  localparam logic [ADDR_W:0]   WIN_L = (ADDR_W+1)'(WIN_BYTES);

  logic in_win;
  logic ctl_hit;
  logic sts_hit;

  always_comb begin
    in_win  = {1'b0, addr} < WIN_L;
    ctl_hit = in_win && (addr == CTL_A);
    sts_hit = in_win && (addr == STS_A);
    ctl_wr  = req && we && ctl_hit;
    ctl_rd  = req && !we && ctl_hit;
    sts_rd  = req && !we && sts_hit;
    any_rd  = req && !we;
  end
endmodule

// File: rtl/twi_fe_ctl.sv
module twi_fe_ctl
  import twi_fe_pkg::*;
#(
  parameter bit CLEAR_ON_ONE = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  byte_t wdata,
  input  logic  evt,
  output ctl_t  ctl,
  output logic  stop_req,
  output logic  nack_req
);
  logic clr_hit;

  generate
    if (CLEAR_ON_ONE) begin : g_w1c
      assign clr_hit = wdata[CB_FLAG];
    end else begin : g_w0c
      assign clr_hit = ~wdata[CB_FLAG];
    end
  endgenerate

  // write side effects are dropped when an event lands in the same cycle
  assign stop_req = wr && !evt && wdata[CB_STOP];
  assign nack_req = wr && !evt && !wdata[CB_ACK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr) begin
        ctl.ien <= wdata[CB_IEN];
        ctl.ben <= wdata[CB_BEN];
        ctl.sp5 <= wdata[CB_SP5];
        ctl.ack <= wdata[CB_ACK];
        ctl.lo  <= wdata[1:0];
      end
      if (evt)
        ctl.flag <= 1'b1;
      else if (wr && clr_hit)
        ctl.flag <= 1'b0;
    end
  end
endmodule

// File: rtl/twi_fe_status.sv
module twi_fe_status
  import twi_fe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  evt,
  input  byte_t evt_code,
  input  logic  stop_req,
  input  logic  nack_req,
  output byte_t sts
);
  byte_t sts_d;

  always_comb begin
    sts_d = sts;
    if (evt)
      sts_d = evt_code;
    else if (stop_req)
      sts_d = ST_IDLE;
    else if (nack_req && sts == ST_RX_ACK)
      sts_d = ST_RX_NACK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= ST_IDLE;
    else        sts <= sts_d;
  end
endmodule

// File: rtl/twi_irq_front.sv
module twi_irq_front
  import twi_fe_pkg::*;
#(
  parameter bit CLEAR_ON_ONE = 1'b0,
  parameter int ADDR_W       = 6,
  parameter int WIN_BYTES    = 36,
  parameter int CTL_OFF      = 12,
  parameter int STS_OFF      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rvalid,
  input  logic              evt_valid,
  input  logic [7:0]        evt_code,
  output logic              irq
);
  logic  ctl_wr, ctl_rd, sts_rd, any_rd;
  logic  stop_req, nack_req;
  ctl_t  ctl_q;
  byte_t sts_q;

  twi_fe_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .CTL_OFF(CTL_OFF), .STS_OFF(STS_OFF)
  ) u_dec (
    .req(req), .we(we), .addr(addr),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .sts_rd(sts_rd), .any_rd(any_rd)
  );

  twi_fe_ctl #(.CLEAR_ON_ONE(CLEAR_ON_ONE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(wdata), .evt(evt_valid),
    .ctl(ctl_q), .stop_req(stop_req), .nack_req(nack_req)
  );

  twi_fe_status u_sts (
    .clk(clk), .rst_n(rst_n), .evt(evt_valid), .evt_code(evt_code),
    .stop_req(stop_req), .nack_req(nack_req), .sts(sts_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= any_rd;
      if (any_rd) begin
        if (ctl_rd)      rdata <= ctl_to_byte(ctl_q);
        else if (sts_rd) rdata <= sts_q;
        else             rdata <= '0;
      end
    end
  end

  assign irq = ctl_q.flag && ctl_q.ien;
endmodule

// File: rtl/twi_irq_front_chk.sv
module twi_irq_front_chk
  import twi_fe_pkg::*;
#(
  parameter bit CLEAR_ON_ONE = 1'b0,
  parameter int ADDR_W       = 6,
  parameter int STS_OFF      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              rvalid,
  input logic              evt_valid,
  input logic [7:0]        evt_code,
  input logic              irq,
  input logic              ctl_wr,
  input ctl_t              ctl_q,
  input byte_t             sts_q
);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFF);

  p_evt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (ctl_q.flag && sts_q == $past(evt_code)));

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.flag || !ctl_q.ien) |-> !irq);

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!CLEAR_ON_ONE && ctl_wr && !wdata[CB_FLAG] && !evt_valid) |=> !ctl_q.flag);

  p_clear_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (CLEAR_ON_ONE && ctl_wr && wdata[CB_FLAG] && !evt_valid) |=> (!ctl_q.flag && !irq));

  p_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (CLEAR_ON_ONE && ctl_wr && !wdata[CB_FLAG] && !evt_valid) |=> $stable(ctl_q.flag));

  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[CB_STOP] && !evt_valid) |=> sts_q == ST_IDLE);

  p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && evt_valid) |=> ctl_q.flag);

  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);

  p_no_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);

  p_sts_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == STS_A && !evt_valid) |=> $stable(sts_q));
endmodule

bind twi_irq_front twi_irq_front_chk #(
  .CLEAR_ON_ONE(CLEAR_ON_ONE), .ADDR_W(ADDR_W), .STS_OFF(STS_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .rvalid(rvalid), .evt_valid(evt_valid), .evt_code(evt_code), .irq(irq),
  .ctl_wr(ctl_wr), .ctl_q(ctl_q), .sts_q(sts_q)
);

// File: tb/sim_twi_irq_front.sv
module sim_twi_irq_front;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, req, we, evt_valid;
  logic [5:0] addr;
  logic [7:0] wdata, evt_code;
  logic [7:0] rdata0, rdata1;
  logic       rvalid0, rvalid1, irq0, irq1;

  twi_irq_front #(.CLEAR_ON_ONE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata0), .rvalid(rvalid0), .evt_valid(evt_valid), .evt_code(evt_code), .irq(irq0)
  );
  twi_irq_front #(.CLEAR_ON_ONE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata1), .rvalid(rvalid1), .evt_valid(evt_valid), .evt_code(evt_code), .irq(irq1)
  );

  // reference state built from the requirements
  logic       m_ien, m_ben, m_sp5, m_ack, m_f0, m_f1;
  logic [1:0] m_lo;
  logic [7:0] m_sts;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t q0[$];
  exp_t q1[$];

  int  checks = 0;
  int  errors = 0;
  bit  ended  = 0;

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] ctl_exp(bit flag);
    return {m_ien, m_ben, m_sp5, 1'b0, flag, m_ack, m_lo};
  endfunction

  task automatic rd(logic [5:0] a, string tag);
    exp_t e0, e1;
    e0.tag = {tag, " u0"};
    e1.tag = {tag, " u1"};
    if (a == 6'h0C)      begin e0.v = ctl_exp(m_f0); e1.v = ctl_exp(m_f1); end
    else if (a == 6'h10) begin e0.v = m_sts;         e1.v = m_sts;         end
    else                 begin e0.v = 8'h00;         e1.v = 8'h00;         end
    q0.push_back(e0);
    q1.push_back(e1);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic op(bit do_wr, logic [5:0] a, logic [7:0] d, bit do_ev, logic [7:0] code);
    bit cw;
    cw = do_wr && (a == 6'h0C);
    if (do_ev)                                      m_sts = code;
    else if (cw && d[4])                            m_sts = 8'hF8;
    else if (cw && !d[2] && m_sts == 8'h50)         m_sts = 8'h58;
    if (do_ev) begin m_f0 = 1'b1; m_f1 = 1'b1; end
    else if (cw) begin
      if (!d[3]) m_f0 = 1'b0;
      if (d[3])  m_f1 = 1'b0;
    end
    if (cw) begin
      m_ien = d[7]; m_ben = d[6]; m_sp5 = d[5]; m_ack = d[2]; m_lo = d[1:0];
    end
    req = do_wr; we = do_wr; addr = a; wdata = d;
    evt_valid = do_ev; evt_code = code;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt_valid = 1'b0;
  endtask

  task automatic chk_irq(string tag);
    check8({tag, " irq u0"}, {7'b0, irq0}, {7'b0, m_f0 && m_ien});
    check8({tag, " irq u1"}, {7'b0, irq1}, {7'b0, m_f1 && m_ien});
  endtask

  // monitor: pop expected read data as results come out
  always @(negedge clk) begin
    if (rst_n && rvalid0) begin
      if (q0.size() == 0) check8("R9 spurious rvalid u0", 8'h01, 8'h00);
      else begin exp_t e; e = q0.pop_front(); check8(e.tag, rdata0, e.v); end
    end
    if (rst_n && rvalid1) begin
      if (q1.size() == 0) check8("R9 spurious rvalid u1", 8'h01, 8'h00);
      else begin exp_t e; e = q1.pop_front(); check8(e.tag, rdata1, e.v); end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    evt_valid = 1'b0; evt_code = '0;
    m_ien = 0; m_ben = 0; m_sp5 = 0; m_ack = 0; m_lo = 0; m_f0 = 0; m_f1 = 0;
    m_sts = 8'hF8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_irq("R1");
    rd(6'h0C, "R1 ctl");
    rd(6'h10, "R1 sts");

    // R11 plain bits store
    op(1, 6'h0C, 8'hC4, 0, 8'h00);
    rd(6'h0C, "R11 ctl");
    op(1, 6'h0C, 8'hE7, 0, 8'h00);
    rd(6'h0C, "R11 ctl all plain bits");
    op(1, 6'h0C, 8'hC4, 0, 8'h00);

    // R2 event; R3 irq
    op(0, 6'h00, 8'h00, 1, 8'h20);
    chk_irq("R2 R3");
    rd(6'h0C, "R2 ctl flag");
    rd(6'h10, "R2 sts");

    // stop with ien off: R6, R4 clears, R5 zero keeps
    op(1, 6'h0C, 8'h54, 0, 8'h00);
    chk_irq("R3 R4 R5");
    rd(6'h0C, "R4 R5 R6 ctl");
    rd(6'h10, "R6 sts");

    // flag bit one: R4 keeps (already 0), R5 clears
    op(1, 6'h0C, 8'hCC, 0, 8'h00);
    chk_irq("R5");
    rd(6'h0C, "R5 ctl");

    // R7 nack rewrite; R4 legacy keep with bit one, R5 clear
    op(0, 6'h00, 8'h00, 1, 8'h50);
    chk_irq("R2 R3");
    op(1, 6'h0C, 8'hC8, 0, 8'h00);
    chk_irq("R4 R5");
    rd(6'h10, "R7 sts");
    rd(6'h0C, "R4 R5 ctl");

    // R7 other code untouched; R4 legacy clears, R5 keeps zero
    op(1, 6'h0C, 8'hC0, 0, 8'h00);
    rd(6'h10, "R7 sts other code");
    chk_irq("R4 R5");
    op(0, 6'h00, 8'h00, 1, 8'h40);
    op(1, 6'h0C, 8'hC0, 0, 8'h00);
    rd(6'h10, "R7 sts 40 kept");

    // R8 event wins over clearing write (legacy clear pattern)
    op(1, 6'h0C, 8'hC4, 1, 8'h28);
    chk_irq("R8");
    rd(6'h0C, "R8 ctl");
    rd(6'h10, "R8 sts");

    // R8 event wins over stop and one-to-clear pattern
    op(1, 6'h0C, 8'hDC, 1, 8'h30);
    chk_irq("R8");
    rd(6'h10, "R8 sts stop dropped");
    rd(6'h0C, "R8 R6 ctl");

    // R8 event wins over nack rewrite
    op(0, 6'h00, 8'h00, 1, 8'h50);
    op(1, 6'h0C, 8'hC8, 1, 8'h50);
    rd(6'h10, "R8 sts nack dropped");

    // R10 status read-only
    op(1, 6'h10, 8'h00, 0, 8'h00);
    rd(6'h10, "R10 sts");
    chk_irq("R10");

    // R9 other offsets, back-to-back reads
    rd(6'h00, "R9 off 00");
    rd(6'h20, "R9 off 20");
    rd(6'h3C, "R9 off 3c");
    rd(6'h0C, "R9 ctl b2b");

    // R3 interrupt enable gating
    op(0, 6'h00, 8'h00, 1, 8'h08);
    op(1, 6'h0C, 8'h44, 0, 8'h00);
    chk_irq("R3 ien off");
    op(1, 6'h0C, 8'h80, 0, 8'h00);
    chk_irq("R3 ien back");

    repeat (3) @(negedge clk);
    check8("R9 reads outstanding u0", 8'(q0.size()), 8'h00);
    check8("R9 reads outstanding u1", 8'(q1.size()), 8'h00);
    finish_run();
  end
endmodule